// File: doc/BRIEF.md
# Processor Hotplug Register File

This block is a small register window through which system software brings processors in and out of service. A 32-bit selector register chooses one processor. Every other register in the 12-byte window then reads or updates that processor's state. Each processor has three flags: enabled, insert pending and remove pending. Platform logic raises them through per-processor hot-add and hot-remove request inputs. Software acknowledges them by writing the per-processor control byte.

A command byte changes the meaning of the data registers:

- **Command 0** scans for the lowest-numbered processor with a pending flag and moves the selector onto it.
- **Command 3** exposes the selected processor's 64-bit architecture ID, split across two dwords.
- **Commands 1 and 2** turn the data register into a sink for a status-report event code and a status code. Writing the status code raises a notification pulse carrying both values.

An eject request written through the control byte leaves the block as a one-cycle pulse with the processor index. Reads are combinational from the address, size and current state. Byte data travels on bits 7:0 of the data buses. Writes take effect at the rising clock edge on which the write strobe is high.

A selector value outside 0 to N_CPU-1 parks the window. All reads return 0, and every write except a new selector value is dropped. An enumeration loop that steps the selector one past the last processor therefore reads 0 and stops.

Top module: `hp_cpu_regfile`

## Requirements
- R1: The dword at offset 0 stores any 32-bit value written to it. It is 0 at power-up and is not changed by reset. No other path changes it except a successful command-0 scan.
- R2: While the selector is N_CPU or above, reads at every offset and size return 0. Writes to offsets 4, 5 and 8 have no effect on flags, command, status-report registers or the eject output.
- R3: A byte read at offset 4 returns bit 0 = enabled, bit 1 = insert pending and bit 2 = remove pending for the selected processor. All other bits are 0.
- R4: A byte write at offset 4 clears the insert flag when bit 1 is set and the remove flag when bit 2 is set. When bit 3 is set, eject_pulse is high for exactly the next cycle, with eject_cpu equal to the selected index.
- R5: Writing byte value 0 to offset 5 sets the selector to the lowest index whose insert or remove flag is set. If no flag is set, the selector and all flags stay as they were.
- R6: The dword read at offset 8 returns the selector when the last command was 0. It returns the low 32 bits of the selected processor's architecture ID when the last command was 3, and 0 for any other command.
- R7: The dword read at offset 0 returns the upper 32 bits of the selected processor's architecture ID when the last command was 3, and 0 otherwise.
- R8: A dword write at offset 8 loads ost_event when the last command was 1. It loads ost_status when the last command was 2, and ost_pulse is then high for exactly the next cycle. Under any other command the write changes nothing.
- R9: Offset 5 reads as 0. Any access other than a dword at 0 or 8, or a byte at 4 or 5, reads 0 and writes nothing.
- R10: A hot-add request sets both the enabled and insert flags. A hot-remove request sets the remove flag only if the processor was already enabled.
- R11: A set request arriving in the same cycle as a software clear of the same flag leaves the flag set.
- R12: Reset clears the insert and remove flags, loads the enabled flags from BOOT_MASK, sets the command to 0, zeroes ost_event and ost_status, and drops both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset in the window |
| bus_dword | input | 1 | 1 = dword access, 0 = byte access |
| bus_wdata | input | 32 | Write data (byte on bits 7:0) |
| bus_rdata | output | 32 | Read data for the current address and size |
| hot_add | input | N_CPU | Per-processor hot-add request |
| hot_remove | input | N_CPU | Per-processor hot-remove request |
| eject_pulse | output | 1 | One-cycle eject request |
| eject_cpu | output | IDXW | Processor index of the eject request |
| ost_pulse | output | 1 | One-cycle status-report notification |
| ost_event | output | 32 | Status-report event register |
| ost_status | output | 32 | Status-report status register |

## Verification
Two functions can act on one processor's flag in the same clock cycle: a platform set request (hot-add or hot-remove) and a software clear through the control byte. The bench provokes this by driving a control-byte write that clears both flags on the same clock edge as hot-add and hot-remove for the selected processor. It then reads the status byte, and both flags must still be set. A following plain clear, with no request, must then drop them.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned ID_W   = 64;

    localparam logic [ADDR_W-1:0] OFF_SEL   = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_FLAGS = 4'd4;
    localparam logic [ADDR_W-1:0] OFF_CMD   = 4'd5;
    localparam logic [ADDR_W-1:0] OFF_DATA  = 4'd8;

    typedef enum logic [7:0] {
        CMD_SCAN    = 8'd0,
        CMD_OST_EVT = 8'd1,
        CMD_OST_STS = 8'd2,
        CMD_ARCH_ID = 8'd3
    } hp_cmd_e;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_SEL,
        REG_FLAGS,
        REG_CMD,
        REG_DATA
    } hp_reg_e;

    // bit 0 enabled, bit 1 insert pending, bit 2 remove pending
    typedef struct packed {
        logic rm;
        logic ins;
        logic en;
    } hp_flags_t;

    function automatic hp_reg_e hp_decode(logic [ADDR_W-1:0] addr, logic dword);
        hp_reg_e kind;
        kind = REG_NONE;
        if (dword && addr == OFF_SEL)        kind = REG_SEL;
        else if (!dword && addr == OFF_FLAGS) kind = REG_FLAGS;
        else if (!dword && addr == OFF_CMD)   kind = REG_CMD;
        else if (dword && addr == OFF_DATA)   kind = REG_DATA;
        return kind;
    endfunction

    function automatic logic [7:0] hp_status_byte(hp_flags_t f);
        return {5'b0, f};
    endfunction

endpackage

// File: rtl/hp_flag_slot.sv
module hp_flag_slot
    import hp_pkg::*;
#(
    parameter bit BOOT_EN = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      add_req,
    input  logic      rm_req,
    input  logic      clr_ins,
    input  logic      clr_rm,
    output hp_flags_t flags
);

    // set requests dominate same-cycle clears
    always_ff @(posedge clk) begin
        if (rst) begin
            flags.en  <= BOOT_EN;
            flags.ins <= 1'b0;
            flags.rm  <= 1'b0;
        end else begin
            flags.en  <= flags.en | add_req;
            flags.ins <= (flags.ins & ~clr_ins) | add_req;
            flags.rm  <= (flags.rm & ~clr_rm) | (rm_req & flags.en);
        end
    end

endmodule

// File: rtl/hp_pend_scan.sv
module hp_pend_scan #(
    parameter int unsigned N    = 4,
    parameter int unsigned IDXW = 2
) (
    input  logic [N-1:0]    pend,
    output logic            found,
    output logic [IDXW-1:0] idx
);

    // lowest set index wins: later (lower) iterations overwrite
    always_comb begin
        found = |pend;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDXW'(i);
        end
    end

endmodule

// File: rtl/hp_cpu_regfile.sv
module hp_cpu_regfile
    import hp_pkg::*;
#(
    parameter int unsigned           N_CPU     = 4,
    parameter logic [N_CPU-1:0]      BOOT_MASK = N_CPU'(1),
    parameter logic [N_CPU*ID_W-1:0] ARCH_ID   = {64'hC0DE0003_00000307,
                                                  64'hC0DE0002_00000205,
                                                  64'hC0DE0001_00000103,
                                                  64'hC0DE0000_00000001},
    localparam int unsigned IDXW = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_dword,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CPU-1:0]  hot_add,
    input  logic [N_CPU-1:0]  hot_remove,
    output logic              eject_pulse,
    output logic [IDXW-1:0]   eject_cpu,
    output logic              ost_pulse,
    output logic [DATA_W-1:0] ost_event,
    output logic [DATA_W-1:0] ost_status
);

    localparam logic [DATA_W-1:0] SEL_LIMIT = DATA_W'(N_CPU);

    // selector survives reset; power-up value is a valid index
    logic [DATA_W-1:0] sel_q = '0;
    logic [7:0]        cmd_q;
    logic              sel_ok;
    logic [IDXW-1:0]   cur;
    hp_reg_e           reg_kind;

    logic wr_sel, wr_flags, wr_cmd, wr_data;

    hp_flags_t        flags_arr [N_CPU];
    logic [N_CPU-1:0] en_vec, ins_vec, rm_vec, pend_vec;
    logic [N_CPU-1:0] clr_ins_vec, clr_rm_vec;

    logic            scan_found;
    logic [IDXW-1:0] scan_idx;
    logic [ID_W-1:0] cur_id;

    assign sel_ok   = (sel_q < SEL_LIMIT);
    assign cur      = sel_q[IDXW-1:0];
    assign reg_kind = hp_decode(bus_addr, bus_dword);

    assign wr_sel   = bus_wr && (reg_kind == REG_SEL);
    assign wr_flags = bus_wr && sel_ok && (reg_kind == REG_FLAGS);
    assign wr_cmd   = bus_wr && sel_ok && (reg_kind == REG_CMD);
    assign wr_data  = bus_wr && sel_ok && (reg_kind == REG_DATA);

    // per-processor flag storage
    for (genvar g = 0; g < N_CPU; g++) begin : g_slot
        assign clr_ins_vec[g] = wr_flags && (cur == IDXW'(g)) && bus_wdata[1];
        assign clr_rm_vec[g]  = wr_flags && (cur == IDXW'(g)) && bus_wdata[2];

        hp_flag_slot #(
            .BOOT_EN (BOOT_MASK[g])
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .add_req (hot_add[g]),
            .rm_req  (hot_remove[g]),
            .clr_ins (clr_ins_vec[g]),
            .clr_rm  (clr_rm_vec[g]),
            .flags   (flags_arr[g])
        );

        assign en_vec[g]   = flags_arr[g].en;
        assign ins_vec[g]  = flags_arr[g].ins;
        assign rm_vec[g]   = flags_arr[g].rm;
        assign pend_vec[g] = flags_arr[g].ins | flags_arr[g].rm;
    end

    hp_pend_scan #(
        .N    (N_CPU),
        .IDXW (IDXW)
    ) u_scan (
        .pend  (pend_vec),
        .found (scan_found),
        .idx   (scan_idx)
    );

    assign cur_id = ARCH_ID[{cur, 6'b0} +: ID_W];

    // selector: direct write, or landing point of a successful scan
    always_ff @(posedge clk) begin
        if (wr_sel) begin
            sel_q <= bus_wdata;
        end else if (wr_cmd && bus_wdata[7:0] == CMD_SCAN && scan_found) begin
            sel_q <= DATA_W'(scan_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= CMD_SCAN;
            ost_event   <= '0;
            ost_status  <= '0;
            ost_pulse   <= 1'b0;
            eject_pulse <= 1'b0;
            eject_cpu   <= '0;
        end else begin
            ost_pulse   <= 1'b0;
            eject_pulse <= 1'b0;
            if (wr_cmd) cmd_q <= bus_wdata[7:0];
            if (wr_data && cmd_q == CMD_OST_EVT) ost_event <= bus_wdata;
            if (wr_data && cmd_q == CMD_OST_STS) begin
                ost_status <= bus_wdata;
                ost_pulse  <= 1'b1;
            end
            if (wr_flags && bus_wdata[3]) begin
                eject_pulse <= 1'b1;
                eject_cpu   <= cur;
            end
        end
    end

    // read mux: everything reads 0 while the selector is parked
    always_comb begin
        bus_rdata = '0;
        if (sel_ok) begin
            case (reg_kind)
                REG_SEL: begin
                    if (cmd_q == CMD_ARCH_ID) bus_rdata = cur_id[63:32];
                end
                REG_FLAGS: begin
                    bus_rdata[7:0] = hp_status_byte(flags_arr[cur]);
                end
                REG_DATA: begin
                    if (cmd_q == CMD_SCAN)         bus_rdata = sel_q;
                    else if (cmd_q == CMD_ARCH_ID) bus_rdata = cur_id[31:0];
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/hp_regfile_chk.sv
module hp_regfile_chk #(
    parameter int unsigned N_CPU = 4,
    localparam int unsigned IDXW = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic             bus_dword,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [31:0]      sel_q,
    input logic [7:0]       cmd_q,
    input logic [N_CPU-1:0] en_vec,
    input logic [N_CPU-1:0] ins_vec,
    input logic [N_CPU-1:0] rm_vec,
    input logic [N_CPU-1:0] hot_add,
    input logic             eject_pulse,
    input logic             ost_pulse
);

    localparam logic [31:0] NLIM = 32'(N_CPU);

    // R2: a parked selector blanks every read
    a_r2_invalid_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (sel_q >= NLIM) |-> (bus_rdata == 32'd0));

    // R1: selector moves only on a bus write
    a_r1_sel_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(sel_q));

    // R4: eject pulse only follows a valid control write with bit 3
    a_r4_eject_cause: assert property (@(posedge clk) disable iff (rst)
        eject_pulse |-> $past(bus_wr && !bus_dword && bus_addr == 4'd4
                              && bus_wdata[3] && sel_q < NLIM));

    // R8: notification only follows a valid status write under command 2
    a_r8_ost_cause: assert property (@(posedge clk) disable iff (rst)
        ost_pulse |-> $past(bus_wr && bus_dword && bus_addr == 4'd8
                            && cmd_q == 8'd2 && sel_q < NLIM));

    // R5: a scan with something pending lands on a pending processor
    a_r5_scan_lands: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_dword && bus_addr == 4'd5 && bus_wdata[7:0] == 8'd0
         && sel_q < NLIM && |(ins_vec | rm_vec))
        |=> (ins_vec[sel_q[IDXW-1:0]] || rm_vec[sel_q[IDXW-1:0]]));

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        // R10: remove-pending never exists without enabled
        a_r10_rm_implies_en: assert property (@(posedge clk) disable iff (rst)
            rm_vec[i] |-> en_vec[i]);

        // R11: a hot-add always lands, whatever software clears
        a_r11_add_wins: assert property (@(posedge clk) disable iff (rst)
            hot_add[i] |=> (ins_vec[i] && en_vec[i]));
    end

endmodule

bind hp_cpu_regfile hp_regfile_chk #(.N_CPU(N_CPU)) u_chk (.*);

// File: tb/tb_hp_cpu_regfile.sv
module tb_hp_cpu_regfile;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic        bus_dword;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [N-1:0] hot_add;
    logic [N-1:0] hot_remove;
    logic        eject_pulse;
    logic [1:0]  eject_cpu;
    logic        ost_pulse;
    logic [31:0] ost_event;
    logic [31:0] ost_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hp_cpu_regfile dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_dword   (bus_dword),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .hot_add     (hot_add),
        .hot_remove  (hot_remove),
        .eject_pulse (eject_pulse),
        .eject_cpu   (eject_cpu),
        .ost_pulse   (ost_pulse),
        .ost_event   (ost_event),
        .ost_status  (ost_status)
    );

    function automatic logic [31:0] id_lo(int i);
        return 32'((i << 8) | (2 * i + 1));
    endfunction

    function automatic logic [31:0] id_hi(int i);
        return 32'hC0DE0000 + 32'(i);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic dw, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_dword = dw; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, logic dw, output logic [31:0] d);
        bus_addr = a; bus_dword = dw;
        #1;
        d = bus_rdata;
    endtask

    task automatic sel(int i);
        wr(4'd0, 1'b1, 32'(i));
    endtask

    task automatic cmd(logic [7:0] c);
        wr(4'd5, 1'b0, {24'd0, c});
    endtask

    task automatic hot(logic [N-1:0] a, logic [N-1:0] r);
        @(negedge clk);
        hot_add = a; hot_remove = r;
        @(negedge clk);
        hot_add = '0; hot_remove = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd4, 1'b0, d); chk("R1 R12 power-up sel 0, boot cpu enabled", d, 32'h1);
        chk("R12 ost_event reset", ost_event, 0);
        chk("R12 ost_status reset", ost_status, 0);
        chk("R12 pulses low", {30'd0, eject_pulse, ost_pulse}, 0);
        sel(2);
        rd(4'd4, 1'b0, d); chk("R12 non-boot cpu disabled", d, 32'h0);
        cmd(8'd3);
        do_reset();
        rd(4'd8, 1'b1, d); chk("R1 reset keeps selector, R12 command 0", d, 32'd2);
        sel(0);
    endtask

    task automatic t_hot();
        logic [31:0] d;
        hot('0, 4'b1000);
        sel(3); rd(4'd4, 1'b0, d); chk("R10 remove on disabled cpu ignored", d, 32'h0);
        hot(4'b0100, '0);
        sel(2); rd(4'd4, 1'b0, d); chk("R10 hot-add sets en+ins", d, 32'h3);
        hot('0, 4'b0100);
        rd(4'd4, 1'b0, d); chk("R3 R10 remove on enabled cpu", d, 32'h7);
    endtask

    task automatic t_scan();
        logic [31:0] d;
        hot(4'b0010, '0);
        sel(3); cmd(8'd0);
        rd(4'd8, 1'b1, d); chk("R5 scan picks lowest pending", d, 32'd1);
        rd(4'd4, 1'b0, d); chk("R3 status of scanned cpu", d, 32'h3);
        wr(4'd4, 1'b0, 32'h02);
        rd(4'd4, 1'b0, d); chk("R4 insert clear", d, 32'h1);
        sel(3); cmd(8'd0);
        rd(4'd8, 1'b1, d); chk("R5 scan finds next pending", d, 32'd2);
        wr(4'd4, 1'b0, 32'h06);
        rd(4'd4, 1'b0, d); chk("R4 insert+remove clear", d, 32'h1);
        sel(3); cmd(8'd0);
        rd(4'd8, 1'b1, d); chk("R5 no pending keeps selector", d, 32'd3);
        sel(2);
        rd(4'd4, 1'b0, d); chk("R5 failed scan leaves flags", d, 32'h1);
    endtask

    task automatic t_archid();
        logic [31:0] d;
        sel(2); cmd(8'd3);
        rd(4'd8, 1'b1, d); chk("R6 low id cpu2", d, id_lo(2));
        rd(4'd0, 1'b1, d); chk("R7 high id cpu2", d, id_hi(2));
        sel(0);
        rd(4'd8, 1'b1, d); chk("R6 low id cpu0", d, id_lo(0));
        rd(4'd0, 1'b1, d); chk("R7 high id cpu0", d, id_hi(0));
        cmd(8'd1);
        rd(4'd8, 1'b1, d); chk("R6 data 0 under cmd1", d, 0);
        rd(4'd0, 1'b1, d); chk("R7 offset0 0 under cmd1", d, 0);
        sel(2); cmd(8'd0);
        rd(4'd0, 1'b1, d); chk("R7 offset0 0 under cmd0", d, 0);
        rd(4'd8, 1'b1, d); chk("R6 data is selector under cmd0", d, 32'd2);
    endtask

    task automatic t_ost();
        sel(0); cmd(8'd1);
        wr(4'd8, 1'b1, 32'h11);
        chk("R8 event stored", ost_event, 32'h11);
        chk("R8 no pulse on event", {31'd0, ost_pulse}, 0);
        cmd(8'd2);
        wr(4'd8, 1'b1, 32'h22);
        chk("R8 pulse on status", {31'd0, ost_pulse}, 1);
        chk("R8 status stored", ost_status, 32'h22);
        chk("R8 event kept", ost_event, 32'h11);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'd0, ost_pulse}, 0);
        cmd(8'd0);
        wr(4'd8, 1'b1, 32'h99);
        chk("R8 cmd0 write no event change", ost_event, 32'h11);
        chk("R8 cmd0 write no status change", ost_status, 32'h22);
    endtask

    task automatic t_eject();
        logic [31:0] d;
        sel(1);
        wr(4'd4, 1'b0, 32'h08);
        chk("R4 eject pulse", {31'd0, eject_pulse}, 1);
        chk("R4 eject index", {30'd0, eject_cpu}, 32'd1);
        @(negedge clk);
        chk("R4 eject one cycle", {31'd0, eject_pulse}, 0);
        rd(4'd4, 1'b0, d); chk("R4 eject leaves flags", d, 32'h1);
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        hot(4'b1000, '0);
        sel(1); cmd(8'd1);
        sel(4);
        wr(4'd8, 1'b1, 32'h55);
        chk("R2 data write ignored", ost_event, 32'h11);
        wr(4'd5, 1'b0, 32'h0);
        wr(4'd4, 1'b0, 32'h0A);
        chk("R2 eject ignored", {31'd0, eject_pulse}, 0);
        rd(4'd0, 1'b1, d); chk("R2 offset0 reads 0", d, 0);
        rd(4'd4, 1'b0, d); chk("R2 offset4 reads 0", d, 0);
        rd(4'd8, 1'b1, d); chk("R2 offset8 reads 0", d, 0);
        sel(-1);
        rd(4'd4, 1'b0, d); chk("R2 large selector reads 0", d, 0);
        sel(3);
        rd(4'd4, 1'b0, d); chk("R2 flags untouched while parked", d, 32'h3);
        rd(4'd8, 1'b1, d); chk("R2 command untouched while parked", d, 0);
        sel(0); cmd(8'd0);
        for (int i = 1; i <= N; i++) begin
            sel(i);
            rd(4'd8, 1'b1, d);
            chk("R2 enumeration step", d, (i < N) ? 32'(i) : 32'd0);
        end
        sel(3); wr(4'd4, 1'b0, 32'h02);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        sel(1); cmd(8'd3);
        rd(4'd8, 1'b0, d); chk("R9 byte at 8 reads 0", d, 0);
        rd(4'd4, 1'b1, d); chk("R9 dword at 4 reads 0", d, 0);
        rd(4'd5, 1'b0, d); chk("R9 command reads 0", d, 0);
        rd(4'd12, 1'b1, d); chk("R9 offset 12 reads 0", d, 0);
        wr(4'd5, 1'b1, 32'h0);
        wr(4'd0, 1'b0, 32'h2);
        wr(4'd6, 1'b0, 32'h0);
        rd(4'd8, 1'b1, d); chk("R9 odd-size writes ignored", d, id_lo(1));
    endtask

    task automatic t_collide();
        logic [31:0] d;
        sel(1);
        hot(4'b0010, '0);
        @(negedge clk);
        bus_addr = 4'd4; bus_dword = 1'b0; bus_wdata = 32'h06; bus_wr = 1'b1;
        hot_add = 4'b0010; hot_remove = 4'b0010;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; hot_add = '0; hot_remove = '0;
        rd(4'd4, 1'b0, d); chk("R11 set beats same-cycle clear", d, 32'h7);
        wr(4'd4, 1'b0, 32'h06);
        rd(4'd4, 1'b0, d); chk("R11 later clear works", d, 32'h1);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_dword = 1'b0;
        bus_wdata = '0; hot_add = '0; hot_remove = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hot();
        t_scan();
        t_archid();
        t_ost();
        t_eject();
        t_invalid();
        t_reserved();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule